// File: doc/BRIEF.md
# Hamming Syndrome Corrector

This block checks one 512-byte sector protected by a 24-bit Hamming code. A start pulse loads two codes: the one freshly computed from the sector data and the one read back from the spare area. Their XOR, the syndrome, is held in a register. The block counts the ones in the syndrome through a two-stage registered adder tree and then sorts the result into one of four classes: clean, a single data bit that can be corrected, an uncorrectable error, or an error in the code word itself.

For a correctable error the block reports the byte address (9 bits) and the bit address (3 bits) of the bad data bit. It builds both from the odd-position syndrome bits. When the fix enable was set at start, it also repairs the sector buffer through a byte port. It reads the addressed byte, and in the next cycle it writes that byte back with the one bit inverted. A single-cycle done pulse closes every run. The status and addresses then hold until the next run produces its own result.

The controller has seven states. IDLE waits for start. SUM0 and SUM1 cover the two adder-tree stages. DECIDE classifies the syndrome. It goes to READ when the error is correctable and fix was requested, and to FINISH in every other case. READ issues the buffer read and always moves to MODIFY. MODIFY issues the write and always moves to FINISH. FINISH raises done. From FINISH the controller goes back to SUM0 if start is high again, and to IDLE if it is not. IDLE likewise moves to SUM0 on start.

Top module: `hecc_syndrome_fixer`

## Requirements
- R1: After reset, status is 0, both addresses are 0, and busy, done and both memory enables are low.
- R2: A zero syndrome gives status 0 (clean) and causes no memory access.
- R3: A syndrome with exactly 12 ones gives status 1 (corrected). The bit address is formed as {syn[5], syn[3], syn[1]}. The byte address is formed as {syn[23], syn[21], syn[19], syn[17], syn[15], syn[13], syn[11], syn[9], syn[7]}. Both addresses are 0 whenever the status is not 1.
- R4: A nonzero syndrome with fewer than 23 ones and a count other than 12 gives status 2 (uncorrectable).
- R5: A syndrome with 23 or 24 ones gives status 3 (code error).
- R6: When no repair is done, done is high in the fourth cycle counted from the clock edge that samples start. When a repair is done, done is high in the sixth cycle.
- R7: With fix enabled and status 1, the block reads the byte at the byte address once. In the next cycle it writes that byte back to the same address with the bit selected by the bit address inverted.
- R8: With fix disabled, or with a status other than 1, no read and no write reach the buffer.
- R9: While busy is high, start is ignored, and the running result is unaffected.
- R10: A start pulse that arrives during the done cycle begins a new run at once, with the same latency.
- R11: Status and both addresses keep their values from one result until the next result, even while the code inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load both codes and begin a run |
| fix_en | input | 1 | Repair the buffer when the error is correctable |
| calc_code | input | 24 | Code computed from the sector data |
| stored_code | input | 24 | Code read from the spare area |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| status | output | 2 | 0 clean, 1 corrected, 2 uncorrectable, 3 code error |
| byte_addr | output | 9 | Byte holding the bad bit |
| bit_addr | output | 3 | Bit within that byte |
| mem_rd_en | output | 1 | Buffer read strobe |
| mem_addr | output | 9 | Buffer byte address for the read and the write |
| mem_rd_data | input | 8 | Buffer read data, valid one cycle after the strobe |
| mem_wr_en | output | 1 | Buffer write strobe |
| mem_wr_data | output | 8 | Repaired byte |

## Verification
The done pulse of one run and the acceptance of the next run's start can fall in the same cycle. The bench provokes this by driving start with fresh codes in the very cycle where it first sees done. It then checks three things: that busy rises on the following cycle, that the old status still holds during the new run, and that the second done arrives after the normal latency carrying the new class. A second overlap, a start pulse while the block is busy, is raised mid-run. The bench judges it by confirming that only one done appears and that this done carries the first run's class.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

    typedef enum logic [1:0] {
        CLS_CLEAN   = 2'd0,
        CLS_FIXED   = 2'd1,
        CLS_UNCORR  = 2'd2,
        CLS_CODEERR = 2'd3
    } hecc_class_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SUM0,
        S_SUM1,
        S_DECIDE,
        S_READ,
        S_MODIFY,
        S_FINISH
    } hecc_state_e;

endpackage

// File: rtl/hecc_popcnt.sv
module hecc_popcnt #(
    parameter int W  = 24,
    parameter int GW = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [W-1:0]             vec,
    output logic [$clog2(W+1)-1:0]   total
);
    localparam int NG  = W / GW;
    localparam int GCW = $clog2(GW + 1);
    localparam int TW  = $clog2(W + 1);

    function automatic logic [GCW-1:0] ones(input logic [GW-1:0] v);
        logic [GCW-1:0] c;
        c = '0;
        for (int i = 0; i < GW; i++) begin
            c = c + GCW'(v[i]);
        end
        return c;
    endfunction

    logic [GCW-1:0] grp_q [NG];
    logic [TW-1:0]  sum_c;
    logic [TW-1:0]  total_q;

    // stage 1: one partial count per group
    for (genvar g = 0; g < NG; g++) begin : g_grp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                grp_q[g] <= '0;
            end else begin
                grp_q[g] <= ones(vec[g*GW +: GW]);
            end
        end
    end

    always_comb begin
        sum_c = '0;
        for (int g = 0; g < NG; g++) begin
            sum_c = sum_c + TW'(grp_q[g]);
        end
    end

    // stage 2: total across groups
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total_q <= '0;
        end else begin
            total_q <= sum_c;
        end
    end

    assign total = total_q;

endmodule

// File: rtl/hecc_locate.sv
module hecc_locate #(
    parameter int W   = 24,
    parameter int AW  = 9,
    parameter int BW  = 3
) (
    input  logic [W-1:0]  syn,
    output logic [AW-1:0] byte_addr,
    output logic [BW-1:0] bit_addr
);
    localparam int NODD = AW + BW;

    logic [NODD-1:0] odd;

    // odd-position syndrome bits carry the location, lowest first
    for (genvar k = 0; k < NODD; k++) begin : g_odd
        assign odd[k] = syn[2*k+1];
    end

    assign bit_addr  = odd[BW-1:0];
    assign byte_addr = odd[NODD-1:BW];

endmodule

// File: rtl/hecc_classify.sv
module hecc_classify
    import hecc_pkg::*;
#(
    parameter int W = 24
) (
    input  logic                   is_zero,
    input  logic [$clog2(W+1)-1:0] total,
    output hecc_class_e            cls
);
    localparam int TW   = $clog2(W + 1);
    localparam int HALF = W / 2;
    localparam int NEAR = W - 1;

    always_comb begin
        if (is_zero) begin
            cls = CLS_CLEAN;
        end else if (total >= TW'(NEAR)) begin
            cls = CLS_CODEERR;
        end else if (total == TW'(HALF)) begin
            cls = CLS_FIXED;
        end else begin
            cls = CLS_UNCORR;
        end
    end

endmodule

// File: rtl/hecc_syndrome_fixer.sv
module hecc_syndrome_fixer
    import hecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int CODE_W       = 24,
    parameter int GROUP_W      = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    input  logic                             fix_en,
    input  logic [CODE_W-1:0]                calc_code,
    input  logic [CODE_W-1:0]                stored_code,
    output logic                             busy,
    output logic                             done,
    output logic [1:0]                       status,
    output logic [$clog2(SECTOR_BYTES)-1:0]  byte_addr,
    output logic [2:0]                       bit_addr,
    output logic                             mem_rd_en,
    output logic [$clog2(SECTOR_BYTES)-1:0]  mem_addr,
    input  logic [7:0]                       mem_rd_data,
    output logic                             mem_wr_en,
    output logic [7:0]                       mem_wr_data
);
    localparam int AW    = $clog2(SECTOR_BYTES);
    localparam int BW    = 3;
    localparam int CNT_W = $clog2(CODE_W + 1);

    hecc_state_e      state_q, state_d;
    logic [CODE_W-1:0] syn_q;
    logic              fix_q;
    hecc_class_e       status_q;
    logic [AW-1:0]     byte_q;
    logic [BW-1:0]     bit_q;

    logic [CNT_W-1:0]  total;
    logic [AW-1:0]     loc_byte;
    logic [BW-1:0]     loc_bit;
    hecc_class_e       cls;
    logic              accept;

    hecc_popcnt #(.W(CODE_W), .GW(GROUP_W)) i_popcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .vec   (syn_q),
        .total (total)
    );

    hecc_locate #(.W(CODE_W), .AW(AW), .BW(BW)) i_locate (
        .syn       (syn_q),
        .byte_addr (loc_byte),
        .bit_addr  (loc_bit)
    );

    hecc_classify #(.W(CODE_W)) i_classify (
        .is_zero (syn_q == '0),
        .total   (total),
        .cls     (cls)
    );

    assign accept = start && ((state_q == S_IDLE) || (state_q == S_FINISH));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (accept) state_d = S_SUM0;
            S_SUM0:   state_d = S_SUM1;
            S_SUM1:   state_d = S_DECIDE;
            S_DECIDE: state_d = ((cls == CLS_FIXED) && fix_q) ? S_READ : S_FINISH;
            S_READ:   state_d = S_MODIFY;
            S_MODIFY: state_d = S_FINISH;
            S_FINISH: state_d = accept ? S_SUM0 : S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // operands and held result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            syn_q    <= '0;
            fix_q    <= 1'b0;
            status_q <= CLS_CLEAN;
            byte_q   <= '0;
            bit_q    <= '0;
        end else begin
            if (accept) begin
                syn_q <= calc_code ^ stored_code;
                fix_q <= fix_en;
            end
            if (state_q == S_DECIDE) begin
                status_q <= cls;
                byte_q   <= (cls == CLS_FIXED) ? loc_byte : '0;
                bit_q    <= (cls == CLS_FIXED) ? loc_bit  : '0;
            end
        end
    end

    // outputs
    always_comb begin
        busy        = (state_q != S_IDLE) && (state_q != S_FINISH);
        done        = (state_q == S_FINISH);
        mem_rd_en   = (state_q == S_READ);
        mem_wr_en   = (state_q == S_MODIFY);
        mem_addr    = byte_q;
        mem_wr_data = mem_rd_data ^ (8'h01 << bit_q);
    end

    assign status    = status_q;
    assign byte_addr = byte_q;
    assign bit_addr  = bit_q;

endmodule

// File: rtl/hecc_fixer_checker.sv
module hecc_fixer_checker #(
    parameter int AW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic [1:0]    status,
    input logic [AW-1:0] byte_addr,
    input logic [2:0]    bit_addr,
    input logic          mem_rd_en,
    input logic          mem_wr_en,
    input logic [AW-1:0] mem_addr
);

    assert_read_then_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> (mem_wr_en && $stable(mem_addr)));

    assert_write_only_when_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (status == 2'd1));

    assert_addr_zero_unless_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (status != 2'd1) |-> ((byte_addr == '0) && (bit_addr == '0)));

    assert_result_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> ($stable(status) && $stable(byte_addr) && $stable(bit_addr)));

    assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_no_rw_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

endmodule

bind hecc_syndrome_fixer hecc_fixer_checker #(.AW(9)) i_hecc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .status    (status),
    .byte_addr (byte_addr),
    .bit_addr  (bit_addr),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_addr  (mem_addr)
);

// File: tb/test_hecc_syndrome_fixer.sv
module test_hecc_syndrome_fixer;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    localparam logic [23:0] V_CALC [NV] = '{
        24'hA5C33C, 24'h123456, 24'h000000, 24'h000001, 24'hFFFFFF,
        24'hFFFFFE, 24'h0FFFFF, 24'h000FFF, 24'h0007FF, 24'h001FFF };
    localparam logic [23:0] V_STOR [NV] = '{
        24'hA5C33C, 24'h476103, 24'hAAAAAA, 24'h000000, 24'h000000,
        24'h000000, 24'h000000, 24'h000000, 24'h000000, 24'h000000 };
    localparam logic        V_FIX  [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam logic [1:0]  V_STAT [NV] = '{2'd0, 2'd1, 2'd1, 2'd2, 2'd3, 2'd3, 2'd2, 2'd1, 2'd2, 2'd2};
    localparam logic [8:0]  V_BYTE [NV] = '{9'd0, 9'd0, 9'd511, 9'd0, 9'd0, 9'd0, 9'd0, 9'd7, 9'd0, 9'd0};
    localparam logic [2:0]  V_BIT  [NV] = '{3'd0, 3'd0, 3'd7, 3'd0, 3'd0, 3'd0, 3'd0, 3'd7, 3'd0, 3'd0};
    localparam string       V_TAG  [NV] = '{"R2", "R3", "R7", "R4", "R5", "R5", "R8", "R3", "R4", "R4"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        fix_en = 1'b0;
    logic [23:0] calc_code = '0;
    logic [23:0] stored_code = '0;
    logic        busy, done, mem_rd_en, mem_wr_en;
    logic [1:0]  status;
    logic [8:0]  byte_addr, mem_addr;
    logic [2:0]  bit_addr;
    logic [7:0]  mem_rd_data, mem_wr_data;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [7:0] mem    [512];
    logic [7:0] shadow [512];
    int wr_cnt = 0;
    int rd_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hecc_syndrome_fixer i_hecc_syndrome_fixer (
        .clk(clk), .rst_n(rst_n), .start(start), .fix_en(fix_en),
        .calc_code(calc_code), .stored_code(stored_code),
        .busy(busy), .done(done), .status(status),
        .byte_addr(byte_addr), .bit_addr(bit_addr),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data)
    );

    initial begin
        for (int i = 0; i < 512; i++) begin
            mem[i] = 8'(i * 29 + 7);
        end
    end

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= mem[mem_addr];
            rd_cnt <= rd_cnt + 1;
        end
        if (mem_wr_en) begin
            mem[mem_addr] <= mem_wr_data;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] flip_syn(input int byte_i, input int bit_i);
        logic [11:0] loc;
        logic [23:0] s;
        loc = {9'(byte_i), 3'(bit_i)};
        for (int k = 0; k < 12; k++) begin
            s[2*k+1] = loc[k];
            s[2*k]   = ~loc[k];
        end
        return s;
    endfunction

    // launch at a negedge; returns at the negedge where done is seen
    task automatic launch(input logic [23:0] c, input logic [23:0] s, input logic f, output int cyc);
        calc_code = c; stored_code = s; fix_en = f; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic run(input logic [23:0] c, input logic [23:0] s, input logic f,
                       input logic [1:0] es, input logic [8:0] eb, input logic [2:0] ebit,
                       input string tag);
        int cyc, w0, r0, exp_lat, exp_w;
        logic [7:0] exp_byte;
        w0 = wr_cnt; r0 = rd_cnt;
        launch(c, s, f, cyc);
        exp_w   = (es == 2'd1 && f) ? 1 : 0;
        exp_lat = exp_w ? 6 : 4;
        chk(done == 1'b1 && cyc == exp_lat, "R6", {tag, " latency"}, cyc, exp_lat);
        chk(status == es, tag, "status", status, es);
        chk(byte_addr == eb && bit_addr == ebit, tag, "address",
            {byte_addr, bit_addr}, {eb, ebit});
        chk((wr_cnt - w0) == exp_w && (rd_cnt - r0) == exp_w,
            exp_w ? "R7" : "R8", "buffer accesses", wr_cnt - w0, exp_w);
        if (exp_w == 1) begin
            exp_byte = shadow[eb] ^ (8'h01 << ebit);
            shadow[eb] = exp_byte;
            chk(mem[eb] == exp_byte, "R7", "repaired byte", mem[eb], exp_byte);
        end
        @(negedge clk);
    endtask

    initial begin
        int cyc;
        for (int i = 0; i < 512; i++) shadow[i] = 8'(i * 29 + 7);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(status == 2'd0 && byte_addr == '0 && bit_addr == '0, "R1", "result regs", {status, byte_addr, bit_addr}, 0);
        chk(!busy && !done && !mem_rd_en && !mem_wr_en, "R1", "strobes", {busy, done, mem_rd_en, mem_wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            run(V_CALC[v], V_STOR[v], V_FIX[v], V_STAT[v], V_BYTE[v], V_BIT[v], V_TAG[v]);
        end

        // R3 / R7: every single data-bit flip, repaired in the buffer
        for (int b = 0; b < 512; b++) begin
            for (int k = 0; k < 8; k++) begin
                run(24'h3C5A96, 24'h3C5A96 ^ flip_syn(b, k), 1'b1, 2'd1, 9'(b), 3'(k), "R3");
            end
        end

        // R4: every single code-bit flip
        for (int j = 0; j < 24; j++) begin
            run(24'h5AA5F0, 24'h5AA5F0 ^ (24'h1 << j), 1'b1, 2'd2, 9'd0, 3'd0, "R4");
        end

        // R11: result holds while inputs move without start
        run(24'h0, flip_syn(300, 5), 1'b0, 2'd1, 9'd300, 3'd5, "R3");
        for (int i = 0; i < 8; i++) begin
            calc_code = 24'(i * 24'h111111);
            @(negedge clk);
        end
        chk(status == 2'd1 && byte_addr == 9'd300 && bit_addr == 3'd5, "R11", "held result",
            {status, byte_addr, bit_addr}, {2'd1, 9'd300, 3'd5});

        // R9: start while busy is ignored
        calc_code = 24'h0; stored_code = 24'h0; fix_en = 1'b0; start = 1'b1;
        @(negedge clk);
        calc_code = 24'hFFFFFF;
        @(negedge clk);
        start = 1'b0;
        cyc = 2;
        while (!done && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc == 4 && status == 2'd0, "R9", "first result kept", status, 0);
        cyc = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (done || busy) cyc++;
        end
        chk(cyc == 0, "R9", "no second run", cyc, 0);

        // R10: start in the done cycle
        launch(24'h000001, 24'h0, 1'b0, cyc);
        chk(status == 2'd2, "R10", "first class", status, 2);
        calc_code = 24'hFFFFFF; stored_code = 24'h0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R10", "restart accepted", busy, 1);
        chk(status == 2'd2, "R11", "old status during run", status, 2);
        cyc = 1;
        while (!done && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc == 4 && status == 2'd3, "R10", "second class", status, 3);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule